// File: doc/BRIEF.md
# Conversion Cycle Control Sequencer

This block drives a successive-approximation converter. A request level arrives from another clock domain. While it stays high the sequencer starts conversions back to back. A short request pulse gives exactly one conversion. Each conversion begins with a start strobe one clock wide. The sequencer then watches the converter's end-of-conversion line. After that line returns high, a four-bit recovery counter counts out the settling interval the converter needs before it may be started again.

The counter is preloaded with 11 when the strobe is issued. It holds while the synchronized end-of-conversion line is low. Once the line is high it counts 12, 13, 14 and 15. In the cycle where it sits at 15 with counting enabled, it raises a one-clock ready pulse. That pulse says the result has reached the output buffers. It also clears the captured request. If the request level is still high at that moment, the request is captured again on the following clock and a new strobe follows.

The control flow uses five states:
- `S_IDLE` goes to `S_FIRE` when a request is captured.
- `S_FIRE` goes unconditionally to `S_AWAIT_BUSY`.
- `S_AWAIT_BUSY` goes to `S_CONVERT` when synchronized end-of-conversion is low.
- `S_CONVERT` goes to `S_RECOVER` when synchronized end-of-conversion is high.
- `S_RECOVER` goes to `S_IDLE` on the ready pulse.

Top module: `conv_cycle_seq`

## Requirements
- R1: While rst_n is low, conv_start and ready_pulse are low and the captured request and the counter are cleared. After reset, no conv_start appears until start_lvl is seen high.
- R2: start_lvl and eoc_in each pass through two flops before use. From idle, conv_start is high in the cycle after the fourth rising clock edge at which start_lvl is high.
- R3: conv_start is high for exactly one clock per conversion.
- R4: The recovery counter is loaded with 11 at each conv_start and does not advance while synchronized eoc_in is low. Each clock that eoc_in spends low during recovery delays ready_pulse by one clock.
- R5: ready_pulse is high for one clock. With eoc_in held high, it appears in the cycle after the sixth rising edge at which eoc_in is high: two edges for synchronization, then counts 12, 13, 14 and 15.
- R6: A start_lvl pulse of at least two clocks, low again before ready_pulse, gives exactly one conv_start and one ready_pulse.
- R7: With start_lvl held high, the next conv_start comes three clocks after each ready_pulse (ready in cycle k, strobe in cycle k+3).
- R8: Extra start_lvl pulses while a conversion is in progress, with start_lvl low by the ready pulse, produce no further conv_start.
- R9: conv_start and ready_pulse are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_lvl | input | 1 | Asynchronous conversion request level or pulse |
| eoc_in | input | 1 | Asynchronous end-of-conversion from the converter, low while busy |
| conv_start | output | 1 | One-clock start strobe to the converter |
| ready_pulse | output | 1 | One-clock carry: data transferred, ready for the next cycle |

## Verification
Some properties are checked by assertions on every clock:
- the strobe never lasts more than one cycle;
- strobe and ready never overlap;
- a strobe only appears while a request is captured;
- the counter loads 11 on the strobe and holds when not enabled;
- the ready pulse always clears the captured request.

Other behaviours can only be shown by the bench scenarios, which run against a converter model with a 40-clock busy time:
- the exact latencies from the request edge and from end-of-conversion;
- the three-clock turnaround in continuous mode;
- absorption of extra requests;
- the recovery delay caused by a dropout on end-of-conversion;
- quiet behaviour after a reset in mid-conversion.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    // Sequencer control states
    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_FIRE       = 3'd1,
        S_AWAIT_BUSY = 3'd2,
        S_CONVERT    = 3'd3,
        S_RECOVER    = 3'd4
    } ccs_state_e;

    // Index of each asynchronous input inside the synchronizer bundle
    localparam int unsigned IDX_EOC   = 0;
    localparam int unsigned IDX_START = 1;
    localparam int unsigned N_ASYNC   = 2;

endpackage

// File: rtl/ccs_sync.sv
module ccs_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i[b];
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain_q[LAST];
    end

endmodule

// File: rtl/ccs_req_latch.sv
module ccs_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic req_o
);

    logic req_q;

    // Clear has priority; a request still present re-arms one clock later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     req_q <= 1'b0;
        else if (clr_i) req_q <= 1'b0;
        else if (set_i) req_q <= 1'b1;
    end

    assign req_o = req_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !req_q); // R6

endmodule

// File: rtl/ccs_recovery_cnt.sv
module ccs_recovery_cnt #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned PRELOAD = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic en_i,
    output logic carry_o
);

    localparam logic [WIDTH-1:0] TOP_VAL  = '1;
    localparam logic [WIDTH-1:0] INIT_VAL = WIDTH'(PRELOAD);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= INIT_VAL;
        else if (en_i)   cnt_q <= cnt_q + 1'b1;
    end

    assign carry_o = en_i && (cnt_q == TOP_VAL);

    AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == INIT_VAL)); // R4

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !en_i) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/ccs_fsm.sv
module ccs_fsm
    import ccs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic eoc_s_i,
    input  logic carry_i,
    output logic fire_o,
    output logic win_o
);

    ccs_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (req_i)    state_d = S_FIRE;
            S_FIRE:                     state_d = S_AWAIT_BUSY;
            S_AWAIT_BUSY: if (!eoc_s_i) state_d = S_CONVERT;
            S_CONVERT:    if (eoc_s_i)  state_d = S_RECOVER;
            S_RECOVER:    if (carry_i)  state_d = S_IDLE;
            default:                    state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fire_o = 1'b0;
        win_o  = 1'b0;
        unique case (state_q)
            S_IDLE:       ;
            S_FIRE:       fire_o = 1'b1;
            S_AWAIT_BUSY: ;
            S_CONVERT:    win_o  = 1'b1;
            S_RECOVER:    win_o  = 1'b1;
            default:      ;
        endcase
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o); // R3

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire_o && carry_i)); // R9

    AST_FIRE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> req_i); // R2

endmodule

// File: rtl/conv_cycle_seq.sv
module conv_cycle_seq
    import ccs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_WIDTH   = 4,
    parameter int unsigned CNT_PRELOAD = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_lvl,
    input  logic eoc_in,
    output logic conv_start,
    output logic ready_pulse
);

    logic [N_ASYNC-1:0] raw_in;
    logic [N_ASYNC-1:0] sync_in;
    logic               start_s;
    logic               eoc_s;
    logic               req;
    logic               fire;
    logic               win;
    logic               cnt_en;
    logic               carry;

    assign raw_in[IDX_START] = start_lvl;
    assign raw_in[IDX_EOC]   = eoc_in;

    ccs_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (N_ASYNC)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    assign start_s = sync_in[IDX_START];
    assign eoc_s   = sync_in[IDX_EOC];

    ccs_req_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (start_s),
        .clr_i (carry),
        .req_o (req)
    );

    ccs_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .eoc_s_i (eoc_s),
        .carry_i (carry),
        .fire_o  (fire),
        .win_o   (win)
    );

    // Count only inside the conversion window and only while the converter reports done
    assign cnt_en = win && eoc_s;

    ccs_recovery_cnt #(
        .WIDTH   (CNT_WIDTH),
        .PRELOAD (CNT_PRELOAD)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (fire),
        .en_i    (cnt_en),
        .carry_o (carry)
    );

    assign conv_start  = fire;
    assign ready_pulse = carry;

    AST_READY_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ready_pulse |=> !req); // R5

endmodule

// File: tb/test_conv_cycle_seq.sv
module test_conv_cycle_seq;

    localparam int CONV_LEN    = 40;
    localparam int ENABLED_CYC = 16 - 11;   // counter visits 11..15 while enabled

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_lvl = 1'b0;
    logic eoc_in = 1'b1;
    logic conv_start;
    logic ready_pulse;

    always #4 clk = ~clk;   // 125 MHz

    conv_cycle_seq i_conv_cycle_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_lvl   (start_lvl),
        .eoc_in      (eoc_in),
        .conv_start  (conv_start),
        .ready_pulse (ready_pulse)
    );

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    int starts = 0;
    int readies = 0;
    int last_start = 0;
    int last_ready = 0;
    int eoc_rise = 0;
    int conv_left = 0;
    bit pend = 0;
    bit glitch = 0;
    bit done = 0;

    // Behavioural reference model
    bit sq[$];
    bit eq[$];
    int ph;      // 0 idle, 1 strobe, 2 waiting for busy, 3 converting/recovering
    int need;
    bit lat;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        sq = '{0, 0};
        eq = '{0, 0};
        ph = 0;
        need = ENABLED_CYC;
        lat = 0;
    endtask

    task automatic model_step(bit p_start, bit p_eoc);
        bit s_st;
        bit s_eo;
        bit en;
        bit rp;
        bit lat_n;
        s_st = sq[0];
        s_eo = eq[0];
        en = (ph == 3) && s_eo;
        rp = en && (need == 1);
        lat_n = rp ? 1'b0 : (lat | s_st);
        case (ph)
            0: if (lat) ph = 1;
            1: begin ph = 2; need = ENABLED_CYC; end
            2: if (!s_eo) ph = 3;
            default: begin
                if (rp) ph = 0;
                else if (en) need--;
            end
        endcase
        lat = lat_n;
        void'(sq.pop_front());
        sq.push_back(p_start);
        void'(eq.pop_front());
        eq.push_back(p_eoc);
    endtask

    task automatic tick();
        bit p_start;
        bit p_eoc;
        bit e_cs;
        bit e_rp;
        bit new_eoc;
        p_start = start_lvl;
        p_eoc = eoc_in;
        @(posedge clk);
        cyc++;
        #1;
        if (!rst_n) model_reset();
        else model_step(p_start, p_eoc);
        e_cs = (ph == 1);
        e_rp = (ph == 3) && eq[0] && (need == 1);
        check(conv_start == e_cs, "R3", "conv_start vs model", int'(conv_start), int'(e_cs));
        check(ready_pulse == e_rp, "R5", "ready_pulse vs model", int'(ready_pulse), int'(e_rp));
        check(!(conv_start && ready_pulse), "R9", "strobe/ready overlap", 1, 0);
        if (conv_start) begin starts++; last_start = cyc; end
        if (ready_pulse) begin readies++; last_ready = cyc; end
        // Converter model: busy for CONV_LEN clocks after it samples the strobe
        if (conv_left > 0) conv_left--;
        if (pend) begin conv_left = CONV_LEN; pend = 0; end
        if (conv_start) pend = 1;
        @(negedge clk);
        new_eoc = (conv_left == 0) && !glitch;
        if (new_eoc && !eoc_in) eoc_rise = cyc;
        eoc_in = new_eoc;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_ready();
        int r0;
        r0 = readies;
        for (int i = 0; i < 300 && readies == r0; i++) tick();
    endtask

    task automatic wait_start();
        int s0;
        s0 = starts;
        for (int i = 0; i < 300 && starts == s0; i++) tick();
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        int c0;
        int r;
        int s0;
        int rd0;
        int k;
        model_reset();

        // R1: outputs quiet in reset and no strobe without a request
        run(3);
        check(!conv_start && !ready_pulse, "R1", "outputs during reset", int'(conv_start | ready_pulse), 0);
        rst_n = 1'b1;
        run(8);
        check(starts == 0, "R1", "strobes after reset with no request", starts, 0);

        // R2, R5, R6: single short pulse
        start_lvl = 1'b1;
        c0 = cyc;
        run(3);
        start_lvl = 1'b0;
        wait_ready();
        check(last_start - c0 == 4, "R2", "request to strobe latency", last_start - c0, 4);
        check(last_ready - eoc_rise == 6, "R5", "eoc rise to ready latency", last_ready - eoc_rise, 6);
        run(60);
        check(starts == 1, "R6", "strobes for one pulse", starts, 1);
        check(readies == 1, "R6", "ready pulses for one pulse", readies, 1);

        // R8: second pulse during conversion is absorbed
        s0 = starts;
        rd0 = readies;
        start_lvl = 1'b1;
        run(3);
        start_lvl = 1'b0;
        wait_start();
        run(10);
        start_lvl = 1'b1;
        run(3);
        start_lvl = 1'b0;
        wait_ready();
        run(60);
        check(starts - s0 == 1, "R8", "strobes with extra request", starts - s0, 1);
        check(readies - rd0 == 1, "R8", "ready pulses with extra request", readies - rd0, 1);

        // R7: continuous operation
        start_lvl = 1'b1;
        wait_start();
        for (int n = 0; n < 3; n++) begin
            wait_ready();
            k = last_ready;
            wait_start();
            check(last_start - k == 3, "R7", "ready to next strobe", last_start - k, 3);
        end
        start_lvl = 1'b0;
        s0 = starts;
        wait_ready();
        run(60);
        check(starts == s0, "R7", "no strobe after level drops", starts - s0, 0);

        // R4: eoc dropout during recovery holds the counter
        start_lvl = 1'b1;
        run(3);
        start_lvl = 1'b0;
        wait_start();
        for (int i = 0; i < 100 && eoc_in; i++) tick();
        for (int i = 0; i < 100 && !eoc_in; i++) tick();
        r = eoc_rise;
        run(2);
        glitch = 1'b1;
        run(2);
        glitch = 1'b0;
        wait_ready();
        check(last_ready - r == 8, "R4", "ready delay with eoc dropout", last_ready - r, 8);

        // R1: reset in mid-conversion
        run(20);
        rd0 = readies;
        s0 = starts;
        start_lvl = 1'b1;
        run(3);
        start_lvl = 1'b0;
        wait_start();
        run(5);
        rst_n = 1'b0;
        run(2);
        check(!conv_start && !ready_pulse, "R1", "outputs in mid-run reset", int'(conv_start | ready_pulse), 0);
        rst_n = 1'b1;
        run(80);
        check(readies == rd0, "R1", "ready after mid-run reset", readies - rd0, 0);
        check(starts - s0 == 1, "R1", "strobes after mid-run reset", starts - s0, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule